// File: doc/BRIEF.md
# Hold-Until-Release Three-Way Arbiter

This block shares one resource among three requesters. Each requester raises its own request line and waits for its own grant line. While the arbiter is idle, it serves the waiting requester with the highest priority. Index 0 ranks above index 1, and index 1 ranks above index 2. Once a grant has been issued, it stays with its owner for as long as that owner keeps its request high. No other request can take the grant away in that time.

When the owner lowers its request, the arbiter spends one cycle idle. It then applies priority again to whatever is requesting at that point. Every handover therefore passes through the idle state.

The grant outputs are a pure decode of the state register, so they change only on a rising clock edge. There is no combinational path from a request to a grant. Reset is synchronous and active low. The state register can be built as one-hot or as a binary index; a parameter picks the encoding, and the behaviour at the ports is the same in both cases.

Top module: `hold_arbiter`

## Requirements
- R1: A rising clock edge with rst_n low puts the arbiter in idle, and all grant bits read 0 after that edge, whatever the requests are.
- R2: At most one bit of grant_o is 1 in any cycle.
- R3: From idle, an edge that samples req_i[0] high gives grant_o = 3'b001 after that edge, whatever req_i[1] and req_i[2] are.
- R4: From idle, an edge that samples req_i[0] low and req_i[1] high gives grant_o = 3'b010.
- R5: From idle, an edge that samples only req_i[2] high gives grant_o = 3'b100.
- R6: From idle, an edge that samples req_i = 3'b000 leaves grant_o at 3'b000.
- R7: While a grant is held, an edge that samples the owner's request high leaves grant_o unchanged, whatever the other requests are.
- R8: An edge that samples the owner's request low returns the arbiter to idle (grant_o = 3'b000) for at least one cycle. A request that stays high through that cycle is granted at the following edge.
- R9: A grant bit only rises at an edge that sampled the matching request bit high.
- R10: grant_o depends on the state alone. A change of req_i between edges leaves grant_o unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | N_REQ (3) | Request lines; bit i belongs to requester i, bit 0 has the highest priority |
| grant_o | output | N_REQ (3) | Grant lines, at most one high, decoded from the state |

## Verification
The checker watches four behaviours on every cycle: that grants are mutually exclusive, the priority choice made when leaving idle, the hold while the owner keeps its request up, and the return to idle on release. It also checks that no grant bit ever rises without a matching request at the sampling edge. Only the directed scenarios show two further behaviours. The first is that grant_o does not move when req_i changes between edges. The second is the exact one-cycle idle gap when a waiting higher-priority requester takes over from a releasing owner. The bench also shows that an assertion of reset in the middle of a grant clears it.

// File: rtl/hold_arb_pkg.sv
// Shared definitions for the hold-until-release arbiter.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package hold_arb_pkg;

    // Choice of state-register encoding; ports behave identically for both.
    typedef enum logic {
        ENC_BINARY = 1'b0,
        ENC_ONEHOT = 1'b1
    } state_enc_e;

endpackage

// File: rtl/hold_arb_pick.sv
// Priority picker: marks the lowest-index active request.
// Assumes: bit 0 is the highest priority; output is a one-hot or zero vector.
module hold_arb_pick #(
    parameter int N_REQ = 3
) (
    input  logic [N_REQ-1:0] req_i,
    output logic [N_REQ-1:0] pick_o,
    output logic             any_o
);

    // Isolate the lowest set bit and flag whether any request is present.
    always_comb begin
        pick_o = req_i & (~req_i + N_REQ'(1));
        any_o  = |req_i;
    end

endmodule

// File: rtl/hold_arb_state.sv
// State holder of the arbiter: idle or the index of the current owner.
// Assumes: pick_i is one-hot or zero and comes from the priority picker;
// reset is synchronous and active low; owner_o is a pure state decode.
module hold_arb_state
    import hold_arb_pkg::*;
#(
    parameter int         N_REQ = 3,
    parameter state_enc_e ENC   = ENC_ONEHOT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic [N_REQ-1:0] pick_i,
    input  logic             any_i,
    output logic [N_REQ-1:0] owner_o
);

    generate
        if (ENC == ENC_ONEHOT) begin : g_onehot
            logic [N_REQ-1:0] st_q;
            logic [N_REQ-1:0] st_d;

            // Next state: grant from idle by priority, hold while owner requests.
            always_comb begin
                if (st_q == '0) begin
                    st_d = any_i ? pick_i : '0;
                end else if ((st_q & req_i) != '0) begin
                    st_d = st_q;
                end else begin
                    st_d = '0;
                end
            end

            // State register with synchronous active-low reset to idle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            // Moore output: the one-hot state is the grant vector.
            always_comb owner_o = st_q;

        end else begin : g_binary
            localparam int IDXW = $clog2(N_REQ + 1);

            logic [IDXW-1:0] st_q;
            logic [IDXW-1:0] st_d;
            logic [IDXW-1:0] pick_idx;
            logic            own_req;

            // Encode the picked requester as index+1 (0 means idle).
            always_comb begin
                pick_idx = '0;
                for (int i = 0; i < N_REQ; i++) begin
                    if (pick_i[i]) begin
                        pick_idx = IDXW'(i + 1);
                    end
                end
            end

            // Select the current owner's request line.
            always_comb begin
                own_req = 1'b0;
                for (int i = 0; i < N_REQ; i++) begin
                    if (st_q == IDXW'(i + 1)) begin
                        own_req = req_i[i];
                    end
                end
            end

            // Next state: grant from idle by priority, hold while owner requests.
            always_comb begin
                if (st_q == '0) begin
                    st_d = any_i ? pick_idx : '0;
                end else if (own_req) begin
                    st_d = st_q;
                end else begin
                    st_d = '0;
                end
            end

            // State register with synchronous active-low reset to idle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            // Moore output: decode the index into one grant line.
            always_comb begin
                owner_o = '0;
                for (int i = 0; i < N_REQ; i++) begin
                    if (st_q == IDXW'(i + 1)) begin
                        owner_o[i] = 1'b1;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/hold_arbiter.sv
// Top of the hold-until-release arbiter.
// Grants are issued only from idle, by fixed priority (bit 0 highest), and
// are kept until the owner drops its request. Outputs depend on state only.
// Assumes: requests are synchronous to clk; reset is synchronous, active low.
module hold_arbiter
    import hold_arb_pkg::*;
#(
    parameter int         N_REQ = 3,
    parameter state_enc_e ENC   = ENC_ONEHOT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    output logic [N_REQ-1:0] grant_o
);

    logic [N_REQ-1:0] pick;
    logic             any_req;
    logic [N_REQ-1:0] owner;

    hold_arb_pick #(
        .N_REQ (N_REQ)
    ) u_pick (
        .req_i  (req_i),
        .pick_o (pick),
        .any_o  (any_req)
    );

    hold_arb_state #(
        .N_REQ (N_REQ),
        .ENC   (ENC)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .pick_i  (pick),
        .any_i   (any_req),
        .owner_o (owner)
    );

    // Drive the grant lines straight from the decoded state.
    always_comb grant_o = owner;

endmodule

// File: rtl/hold_arbiter_chk.sv
// Property checker for hold_arbiter, attached by bind below.
// Assumes N_REQ >= 3; the priority properties name requesters 0, 1 and 2.
module hold_arbiter_chk #(
    parameter int N_REQ = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] req,
    input logic [N_REQ-1:0] grant
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (grant == '0));

    assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_first_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && req[0]) |=> grant[0]);

    assert_second_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && !req[0] && req[1]) |=> grant[1]);

    assert_third_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && !req[0] && !req[1] && req[2]) |=> grant[2]);

    assert_stay_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && req == '0) |=> (grant == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & req) != '0) |=> $stable(grant));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && (grant & req) == '0) |=> (grant == '0));

    generate
        for (genvar i = 0; i < N_REQ; i++) begin : g_rise
            assert_rise_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(grant[i]) |-> $past(req[i]));
        end
    endgenerate

endmodule

bind hold_arbiter hold_arbiter_chk #(
    .N_REQ (N_REQ)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_i),
    .grant (grant_o)
);

// File: tb/hold_arbiter_bench.sv
`timescale 1ns/1ps
module hold_arbiter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req = 3'b000;
    logic [2:0] grant;
    logic [2:0] req_edge = 3'b000;
    logic [2:0] grant_prev = 3'b000;
    int         n_checks = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    hold_arbiter #(.N_REQ(3)) u_hold_arbiter (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .grant_o (grant)
    );

    task automatic check(input logic [2:0] exp, input string tag);
        n_checks++;
        if (grant !== exp) begin
            n_err++;
            $display("FAIL %s: grant=%b expected=%b", tag, grant, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next fall.
    task automatic step(input logic [2:0] r, input logic [2:0] exp, input string tag);
        req = r;
        @(posedge clk);
        @(negedge clk);
        check(exp, tag);
    endtask

    // R9 monitor: a rising grant bit needs its request at the sampling edge.
    always @(posedge clk) req_edge = req;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 3; i++) begin
                if (grant[i] && !grant_prev[i]) begin
                    n_checks++;
                    if (!req_edge[i]) begin
                        n_err++;
                        $display("FAIL R9: grant bit %0d rose, req=%b expected bit set", i, req_edge);
                    end
                end
            end
        end
        grant_prev = grant;
    end

    task automatic t_reset();
        rst_n = 1'b0;
        step(3'b111, 3'b000, "R1 reset with all requests");
        step(3'b111, 3'b000, "R1 reset held");
        rst_n = 1'b1;
        step(3'b000, 3'b000, "R6 idle after reset");
    endtask

    task automatic t_priority();
        step(3'b111, 3'b001, "R3 req0 wins all");
        step(3'b000, 3'b000, "R8 release req0");
        step(3'b110, 3'b010, "R4 req1 over req2");
        step(3'b000, 3'b000, "R8 release req1");
        step(3'b100, 3'b100, "R5 only req2");
        step(3'b000, 3'b000, "R8 release req2");
        step(3'b000, 3'b000, "R6 no request stays idle");
        step(3'b000, 3'b000, "R6 no request stays idle again");
    endtask

    task automatic t_hold();
        step(3'b010, 3'b010, "R4 req1 alone");
        step(3'b011, 3'b010, "R7 hold against req0");
        step(3'b111, 3'b010, "R7 hold against all");
        step(3'b101, 3'b000, "R8 owner drops, idle gap");
        step(3'b101, 3'b001, "R8 waiting req0 granted after gap");
        step(3'b100, 3'b000, "R8 req0 drops");
        step(3'b100, 3'b100, "R5 req2 granted");
        step(3'b111, 3'b100, "R7 req2 holds against higher");
        step(3'b011, 3'b000, "R8 req2 drops");
        step(3'b000, 3'b000, "R6 back to quiet idle");
    endtask

    task automatic t_moore();
        step(3'b001, 3'b001, "R3 req0 granted");
        req = 3'b000;
        #1;
        check(3'b001, "R10 grant steady after mid-cycle drop");
        req = 3'b110;
        #1;
        check(3'b001, "R10 grant steady after mid-cycle change");
        req = 3'b000;
        @(posedge clk);
        @(negedge clk);
        check(3'b000, "R8 released at edge");
    endtask

    task automatic t_reset_mid();
        step(3'b100, 3'b100, "R5 grant before reset");
        rst_n = 1'b0;
        step(3'b100, 3'b000, "R1 reset clears held grant");
        rst_n = 1'b1;
        step(3'b100, 3'b100, "R5 regranted after reset");
        step(3'b000, 3'b000, "R8 final release");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_priority();
        t_hold();
        t_moore();
        t_reset_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule